// File: doc/BRIEF.md
# Shift and Rotate Execution Unit with Condition Flags

This block is the shift and rotate stage of a processor datapath. It takes one operand of 8, 16 or 32 bits and a shift count. It performs one of eight operations: arithmetic shift, logical shift, plain rotate, or rotate through the extend bit, each to the left or to the right. It produces the sized result and the five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C). The flags follow the usual processor rules, including the special cases for a zero count.

A request is presented with `in_valid`. The result and flags appear in registers one clock later with `out_valid`. A memory-word mode turns the request into a 16-bit operation by exactly one position. Operand bits above the selected size pass through unchanged, so the caller can write the whole register back.

Top module: `shiftrot_unit`

## Requirements
- R1: `op_type` encodes 0 as arithmetic shift, 1 as logical shift, 2 as rotate through extend and 3 as plain rotate. `dir_left` selects left (1) or right (0). `size` selects 0 for byte, 1 for word and 2 for long, and 3 is treated as long. A request accepted while `in_valid` is high shows up one clock later with `out_valid` high. `out_valid` is low in any cycle after an idle cycle, and out of reset `out_valid`, `result` and the flags are all zero.
- R2: The effective count is the supplied `count` modulo 64. With `mem_form` high, the size is forced to word and the count is forced to 1, whatever `size` and `count` hold.
- R3: A left shift (arithmetic or logical) by a nonzero count fills the vacated bits with zeros. C takes the last bit moved out, which is zero once the count exceeds the width, and X is set equal to C.
- R4: An arithmetic right shift fills the vacated bits with copies of the sign bit, and a logical right shift fills them with zeros. For counts beyond the width the result is all sign bits or all zeros, and C equals the sign or zero. For any nonzero count X equals C.
- R5: A shift of either kind with a zero effective count leaves the operand unchanged, clears C and keeps X at `x_in`.
- R6: For an arithmetic shift, V is set exactly when the sign bit of the result differs from the sign bit of the operand. For logical shifts and all rotates, V is zero.
- R7: A plain rotate turns the operand by (effective count mod width) and never changes X. After a left rotate C equals result bit 0, and after a right rotate C equals the result's top bit.
- R8: Rotate through extend turns the (width+1)-bit value formed by X above the operand by (effective count mod width). The bit that lands in the X position becomes the new X, and C equals the new X.
- R9: Rotate through extend with (effective count mod width) equal to zero leaves the operand unchanged, keeps X, and sets C to `x_in`.
- R10: N is the top bit of the result at the selected size, and Z is set when all bits of the sized result are zero. Result bits above the selected size equal the operand's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; loads the output registers |
| operand | input | 32 | Value to shift or rotate |
| count | input | CNT_W | Shift count, used modulo 64 |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| op_type | input | 2 | 0 arithmetic, 1 logical, 2 rotate through X, 3 rotate |
| dir_left | input | 1 | 1 left, 0 right |
| x_in | input | 1 | Current extend flag |
| mem_form | input | 1 | Forces word size and a count of one |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Result; bits above the size copied from the operand |
| flag_x | output | 1 | Updated extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench builds the unit with its default `CNT_W` of 8. Counts therefore run to 255, which makes modulo-64 folding, counts equal to the width and counts far past every width all reachable at each of the three sizes. Directed requests cover the zero-count rules of both the shift and the extend-rotate families, and randomized requests mix sizes, directions, the memory-word mode and the incoming X value.

// File: rtl/shr_pkg.sv
`timescale 1ns/1ps
package shr_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned AMT_W  = 6;
  localparam int unsigned LANES  = $clog2(DATA_W / 8) + 1;

  typedef enum logic [1:0] {
    OP_ASH = 2'd0,
    OP_LSH = 2'd1,
    OP_ROX = 2'd2,
    OP_ROT = 2'd3
  } shr_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } shr_size_e;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              c;
    logic              x_wr;
    logic              x_val;
    logic              v;
  } lane_out_t;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    lane_mask = DATA_W'(32'h0000_00FF);
      2'd1:    lane_mask = DATA_W'(32'h0000_FFFF);
      default: lane_mask = '1;
    endcase
  endfunction

  function automatic logic [4:0] lane_msb(input logic [1:0] sel);
    case (sel)
      2'd0:    lane_msb = 5'd7;
      2'd1:    lane_msb = 5'd15;
      default: lane_msb = 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/shr_shift_lane.sv
`timescale 1ns/1ps
module shr_shift_lane
  import shr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     val,
  input  logic [AMT_W-1:0] amt,
  input  logic             arith,
  input  logic             left,
  output lane_out_t        o
);

  logic [W:0]        lwide;
  logic signed [W:0] ars;
  logic [W:0]        lrs;
  logic [W:0]        rwide;
  logic [W-1:0]      r;
  logic              cbit;

  always_comb begin
    // Left: bit W catches the last bit pushed out.
    lwide = {1'b0, val} << amt;
    // Right: a guard bit under the LSB catches the last bit pushed out.
    ars   = $signed({val, 1'b0}) >>> amt;
    lrs   = {val, 1'b0} >> amt;
    rwide = arith ? $unsigned(ars) : lrs;
    r     = left ? lwide[W-1:0] : rwide[W:1];
    cbit  = (amt != '0) & (left ? lwide[W] : rwide[0]);

    o.res   = DATA_W'(r);
    o.c     = cbit;
    o.x_wr  = (amt != '0);
    o.x_val = cbit;
    o.v     = arith & (r[W-1] ^ val[W-1]);
  end

endmodule

// File: rtl/shr_rot_lane.sv
`timescale 1ns/1ps
module shr_rot_lane
  import shr_pkg::*;
#(
  parameter int W  = 8,
  localparam int KW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [KW-1:0] k,
  input  logic          xin,
  input  logic          ext,
  input  logic          left,
  output lane_out_t     o
);

  logic [W-1:0] rol;
  logic [W-1:0] ror;
  logic [W:0]   e;
  logic [W:0]   xl;
  logic [W:0]   xr;
  logic [W:0]   xsel;
  logic         kzero;

  always_comb begin
    kzero = (k == '0);
    rol   = (val << k) | (val >> (W - 32'(k)));
    ror   = (val >> k) | (val << (W - 32'(k)));
    // Extend rotate works on a (W+1)-bit ring with X on top.
    e     = {xin, val};
    xl    = (e << k) | (e >> (W + 1 - 32'(k)));
    xr    = (e >> k) | (e << (W + 1 - 32'(k)));
    xsel  = left ? xl : xr;

    if (ext) begin
      o.res   = DATA_W'(kzero ? val : xsel[W-1:0]);
      o.c     = kzero ? xin : xsel[W];
      o.x_wr  = !kzero;
      o.x_val = xsel[W];
    end else begin
      o.res   = DATA_W'(left ? rol : ror);
      o.c     = left ? rol[0] : ror[W-1];
      o.x_wr  = 1'b0;
      o.x_val = 1'b0;
    end
    o.v = 1'b0;
  end

endmodule

// File: rtl/shiftrot_unit.sv
`timescale 1ns/1ps
module shiftrot_unit
  import shr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  logic [1:0]        size,
  input  logic [1:0]        op_type,
  input  logic              dir_left,
  input  logic              x_in,
  input  logic              mem_form,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_x,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);

  logic [AMT_W-1:0]  amt_eff;
  logic [1:0]        lane_sel;
  logic              arith;
  logic              ext_mode;
  lane_out_t         sh_o [LANES];
  lane_out_t         rt_o [LANES];
  lane_out_t         pick;
  logic [DATA_W-1:0] lmask;

  logic [DATA_W-1:0] res_n;
  logic              x_n, n_n, z_n, v_n, c_n;

  // Request decode
  always_comb begin
    amt_eff  = mem_form ? AMT_W'(1) : AMT_W'(count % 64);
    arith    = (shr_op_e'(op_type) == OP_ASH);
    ext_mode = (shr_op_e'(op_type) == OP_ROX);
    if (mem_form) begin
      lane_sel = 2'd1;
    end else begin
      case (shr_size_e'(size))
        SZ_BYTE: lane_sel = 2'd0;
        SZ_WORD: lane_sel = 2'd1;
        default: lane_sel = 2'd2;
      endcase
    end
  end

  // One shifter and one rotator per operand size
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    localparam int W  = 8 << gi;
    localparam int KW = $clog2(W);

    shr_shift_lane #(.W(W)) u_sh (
      .val   (operand[W-1:0]),
      .amt   (amt_eff),
      .arith (arith),
      .left  (dir_left),
      .o     (sh_o[gi])
    );

    shr_rot_lane #(.W(W)) u_rt (
      .val  (operand[W-1:0]),
      .k    (amt_eff[KW-1:0]),
      .xin  (x_in),
      .ext  (ext_mode),
      .left (dir_left),
      .o    (rt_o[gi])
    );
  end

  // Next-state: lane select, merge and flags
  always_comb begin
    pick  = op_type[1] ? rt_o[lane_sel] : sh_o[lane_sel];
    lmask = lane_mask(lane_sel);
    res_n = (operand & ~lmask) | (pick.res & lmask);
    n_n   = pick.res[lane_msb(lane_sel)];
    z_n   = ((pick.res & lmask) == '0);
    v_n   = pick.v;
    c_n   = pick.c;
    x_n   = pick.x_wr ? pick.x_val : x_in;
  end

  // Output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_x    <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_n;
        flag_x <= x_n;
        flag_n <= n_n;
        flag_z <= z_n;
        flag_v <= v_n;
        flag_c <= c_n;
      end
    end
  end

endmodule

// File: rtl/shiftrot_unit_chk.sv
`timescale 1ns/1ps
module shiftrot_unit_chk
  import shr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] operand,
  input logic [CNT_W-1:0]  count,
  input logic [1:0]        size,
  input logic [1:0]        op_type,
  input logic              x_in,
  input logic              mem_form,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              flag_x,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c
);

  logic [1:0]        p_sel;
  logic [1:0]        p_op;
  logic [AMT_W-1:0]  p_amt;
  logic              p_x;
  logic [DATA_W-1:0] p_opd;
  logic [DATA_W-1:0] sized;
  logic              top_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sel <= 2'd0;
      p_op  <= 2'd0;
      p_amt <= '0;
      p_x   <= 1'b0;
      p_opd <= '0;
    end else if (in_valid) begin
      p_sel <= mem_form ? 2'd1 : ((size == 2'd3) ? 2'd2 : size);
      p_op  <= op_type;
      p_amt <= mem_form ? AMT_W'(1) : AMT_W'(count % 64);
      p_x   <= x_in;
      p_opd <= operand;
    end
  end

  always_comb begin
    case (p_sel)
      2'd0:    begin sized = {24'd0, result[7:0]};  top_bit = result[7];  end
      2'd1:    begin sized = {16'd0, result[15:0]}; top_bit = result[15]; end
      default: begin sized = result;                top_bit = result[31]; end
    endcase
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r10_zflag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_z == (sized == '0)));

  a_r10_nflag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_n == top_bit));

  a_r10_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && p_sel == 2'd0) |-> (result[31:8] == p_opd[31:8]));

  a_r6_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && p_op != 2'd0) |-> !flag_v);

  a_r7_x_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && p_op == 2'd3) |-> (flag_x == p_x));

  a_r3_x_eq_c: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !p_op[1] && p_amt != '0) |-> (flag_x == flag_c));

  a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !p_op[1] && p_amt == '0) |-> (!flag_c && flag_x == p_x));

  a_r8_c_eq_x: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && p_op == 2'd2) |-> (flag_c == flag_x));

endmodule

bind shiftrot_unit shiftrot_unit_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .operand   (operand),
  .count     (count),
  .size      (size),
  .op_type   (op_type),
  .x_in      (x_in),
  .mem_form  (mem_form),
  .out_valid (out_valid),
  .result    (result),
  .flag_x    (flag_x),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_v    (flag_v),
  .flag_c    (flag_c)
);

// File: tb/shiftrot_unit_tb_top.sv
`timescale 1ns/1ps
module shiftrot_unit_tb_top;

  localparam int CNT_W = 8;

  typedef struct {
    bit          vld;
    logic [31:0] r;
    bit          x, n, z, v, c;
    string       tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [31:0]      operand;
  logic [CNT_W-1:0] count;
  logic [1:0]       size;
  logic [1:0]       op_type;
  logic             dir_left;
  logic             x_in;
  logic             mem_form;
  logic             out_valid;
  logic [31:0]      result;
  logic             flag_x, flag_n, flag_z, flag_v, flag_c;

  string cur_tag = "R1";
  exp_t  q[$];
  int    checks = 0;
  int    bad    = 0;

  always #2.5 clk = ~clk;

  shiftrot_unit #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .count(count), .size(size), .op_type(op_type), .dir_left(dir_left),
    .x_in(x_in), .mem_form(mem_form), .out_valid(out_valid), .result(result),
    .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c)
  );

  // Behavioural model: one bit position per loop step
  function automatic exp_t model(input logic [31:0] opd, input int cnt, input int sz,
                                 input int typ, input bit left, input bit xin, input bit mem);
    exp_t e;
    int w, n, k;
    logic [31:0] mask, v;
    bit c, x, o, s, m0;
    w = mem ? 16 : (sz == 0 ? 8 : (sz == 1 ? 16 : 32));
    n = mem ? 1 : (cnt % 64);
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    v = opd & mask;
    m0 = v[w-1];
    x = xin;
    c = 1'b0;
    e.v = 1'b0;
    if (typ < 2) begin
      for (int i = 0; i < n; i++) begin
        if (left) begin
          c = v[w-1];
          v = (v << 1) & mask;
        end else begin
          c = v[0];
          s = v[w-1];
          v = v >> 1;
          if (typ == 0 && s) v[w-1] = 1'b1;
        end
      end
      if (n > 0) x = c;
      e.v = (typ == 0) && (v[w-1] != m0);
    end else if (typ == 3) begin
      k = n % w;
      for (int i = 0; i < k; i++) begin
        if (left) begin
          o = v[w-1];
          v = ((v << 1) & mask) | 32'(o);
        end else begin
          o = v[0];
          v = (v >> 1) | (32'(o) << (w - 1));
        end
      end
      c = left ? v[0] : v[w-1];
    end else begin
      k = n % w;
      for (int i = 0; i < k; i++) begin
        if (left) begin
          o = v[w-1];
          v = ((v << 1) & mask) | 32'(x);
        end else begin
          o = v[0];
          v = (v >> 1) | (32'(x) << (w - 1));
        end
        x = o;
      end
      c = x;
    end
    e.vld = 1'b1;
    e.r = (opd & ~mask) | v;
    e.n = v[w-1];
    e.z = (v == 32'd0);
    e.c = c;
    e.x = x;
    e.tag = "";
    return e;
  endfunction

  // Expectation for every clock, taken from the inputs at the edge
  always @(posedge clk) begin
    if (rst_n) begin
      exp_t e;
      if (in_valid) begin
        e = model(operand, int'(count), int'(size), int'(op_type), dir_left, x_in, mem_form);
      end else begin
        e.vld = 1'b0; e.r = '0; e.x = 0; e.n = 0; e.z = 0; e.v = 0; e.c = 0;
      end
      e.tag = in_valid ? cur_tag : "R1";
      q.push_back(e);
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (out_valid !== e.vld ||
          (e.vld && (result !== e.r || flag_x !== e.x || flag_n !== e.n ||
                     flag_z !== e.z || flag_v !== e.v || flag_c !== e.c))) begin
        bad++;
        $display("FAIL %s: got vld=%0b r=%h xnzvc=%b%b%b%b%b exp vld=%0b r=%h xnzvc=%b%b%b%b%b",
                 e.tag, out_valid, result, flag_x, flag_n, flag_z, flag_v, flag_c,
                 e.vld, e.r, e.x, e.n, e.z, e.v, e.c);
      end
    end
  end

  task automatic op(input string tag, input logic [31:0] opd, input int cnt, input int sz,
                    input int typ, input bit left, input bit xin, input bit mem);
    @(negedge clk);
    cur_tag  = tag;
    in_valid = 1'b1;
    operand  = opd;
    count    = CNT_W'(cnt);
    size     = 2'(sz);
    op_type  = 2'(typ);
    dir_left = left;
    x_in     = xin;
    mem_form = mem;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; operand = '0; count = '0; size = '0;
    op_type = '0; dir_left = 1'b0; x_in = 1'b0; mem_form = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || result !== 32'd0 ||
        {flag_x, flag_n, flag_z, flag_v, flag_c} !== 5'd0) begin
      bad++;
      $display("FAIL R1: got vld=%0b r=%h flags=%b exp vld=0 r=0 flags=0",
               out_valid, result, {flag_x, flag_n, flag_z, flag_v, flag_c});
    end
    rst_n = 1'b1;

    // R3: left shifts, counts inside, at and past the width
    op("R3", 32'h0000_0081, 1, 0, 1, 1, 0, 0);
    op("R3", 32'h0000_00C1, 8, 0, 0, 1, 0, 0);
    op("R3", 32'h0000_00FF, 9, 0, 1, 1, 1, 0);
    op("R3", 32'h8000_0001, 31, 2, 1, 1, 0, 0);
    // R6: arithmetic left overflow and non-overflow
    op("R6", 32'h0000_0040, 1, 0, 0, 1, 0, 0);
    op("R6", 32'h0000_C000, 1, 1, 0, 1, 0, 0);
    // R2: count folding and memory-word form
    op("R2", 32'h1234_5678, 65, 2, 1, 1, 0, 0);
    op("R2", 32'h0000_0003, 64, 0, 1, 0, 1, 0);
    op("R2", 32'hAAAA_8001, 7, 0, 0, 0, 0, 1);
    op("R2", 32'h5555_C003, 200, 2, 2, 1, 1, 1);
    // R4: right shifts
    op("R4", 32'h0000_8001, 4, 1, 0, 0, 0, 0);
    op("R4", 32'h0000_0080, 40, 0, 0, 0, 0, 0);
    op("R4", 32'hFFFF_FFFF, 33, 2, 1, 0, 1, 0);
    op("R4", 32'h8000_0000, 32, 2, 0, 0, 0, 0);
    // R5: zero count on shifts, X held both ways
    op("R5", 32'h0000_0080, 0, 0, 0, 1, 1, 0);
    op("R5", 32'h0000_0000, 128, 1, 1, 0, 0, 0);
    // R7: plain rotates
    op("R7", 32'h0000_0081, 1, 0, 3, 1, 1, 0);
    op("R7", 32'h0000_0005, 3, 1, 3, 0, 0, 0);
    op("R7", 32'h8000_0001, 35, 2, 3, 1, 1, 0);
    op("R7", 32'h0000_00F0, 8, 0, 3, 0, 0, 0);
    // R8: rotate through extend
    op("R8", 32'h0000_0080, 1, 0, 2, 1, 1, 0);
    op("R8", 32'h0000_0031, 5, 1, 2, 0, 0, 0);
    op("R8", 32'h8000_0000, 31, 2, 2, 0, 1, 0);
    // R9: extend rotate with zero effective count
    op("R9", 32'h0000_00A5, 8, 0, 2, 0, 1, 0);
    op("R9", 32'h0000_0000, 0, 1, 2, 1, 1, 0);
    // R10 and R1: upper bits kept, size encoding 3 as long
    op("R10", 32'hDEAD_BE01, 1, 0, 1, 0, 0, 0);
    op("R1", 32'h8000_0000, 1, 3, 0, 0, 0, 0);
    idle();
    idle();

    for (int i = 0; i < 600; i++) begin
      int typ;
      typ = int'($urandom_range(0, 3));
      op(typ == 0 ? "R6" : (typ == 1 ? "R4" : (typ == 2 ? "R8" : "R7")),
         $urandom, int'($urandom_range(0, 255)), int'($urandom_range(0, 3)), typ,
         1'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0));
      if ($urandom_range(0, 9) == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule